// File: doc/BRIEF.md
# Two-Part Transmit Deferral Timer

This block sits in front of the transmit path of a half-duplex Ethernet-style MAC and decides when a frame that does not directly follow the station's own previous frame may start. After a transmit request is raised, it waits for the line to go quiet. It then times an inter-packet gap in two phases, both counted in nibble times. The end of the second phase produces a one-clock start strobe.

The two phases treat carrier sense differently. If carrier appears during the first phase, the station defers. It waits for the line to go idle and then starts the first phase again from zero. Once the first phase has completed, carrier is no longer heeded. The second phase runs to its end and the strobe fires on time, even if that forces a collision. This keeps a station from always losing contention to neighbours that use a shorter gap.

Both gap lengths are 7-bit input ports. Values of 0x0C for the first phase and 0x06 for the second are the customary settings. A status output shows the current phase.

Top module: `txdefer_gap`

## Requirements
- R1: After reset, `phase` is 0 (idle) and `tx_start` is 0.
- R2: In idle, a sampled request moves `phase` to 1 (deferring) if carrier is present, or to 2 (first gap phase) if it is not. From 1, `phase` moves to 2 on the first clock on which carrier is absent.
- R3: In phase 2, carrier present on a clock edge moves `phase` to 1. This takes priority over a tick on the same edge. The first phase then restarts from zero nibble times once the line is idle again.
- R4: In phase 2, the clock edge that samples the `gap1_len`-th tick counted in that phase moves `phase` to 3 (second gap phase).
- R5: In phase 3, carrier is ignored. The phase neither returns to 1 nor restarts its count. The strobe therefore follows exactly `gap1_len + gap2_len` ticks spent in phases 2 and 3, carrier or not.
- R6: A gap length of zero makes that phase complete on its first tick.
- R7: On the edge that samples the `gap2_len`-th tick of phase 3, `tx_start` goes high for exactly one clock and `phase` returns to 0 at the same time.
- R8: With `tx_req` low, `phase` is 0 after the next clock edge from any phase, and no strobe is issued.
- R9: Without a tick, a gap phase holds its phase and its count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nib_tick | input | 1 | One-clock pulse per nibble time |
| crs | input | 1 | Carrier sense |
| tx_req | input | 1 | Transmit request, held until the strobe |
| gap1_len | input | 7 | First gap phase length in nibble times |
| gap2_len | input | 7 | Second gap phase length in nibble times |
| tx_start | output | 1 | One-clock start-transmit strobe |
| phase | output | 2 | Current phase: 0 idle, 1 deferring, 2 first gap, 3 second gap |

## Verification
The bench holds carrier high through the whole second phase. A design that let carrier restart or defer there would either delay the strobe or never issue it. It pulses carrier inside the first phase and then counts the ticks after the line clears. A design that resumed the old count instead of restarting would strobe too early. Zero-length phases are checked to finish on the first tick, which catches a design that counts a full wrap. Requests are also dropped mid-gap, so a leftover count or a stray strobe would appear on the next request.

// File: rtl/txdefer_pkg.sv
package txdefer_pkg;

    localparam int LEN_W = 7;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_DEFER = 2'd1,
        PH_GAP1  = 2'd2,
        PH_GAP2  = 2'd3
    } gap_phase_e;

    typedef struct packed {
        gap_phase_e phase;
        logic       start;
    } ctrl_state_s;

endpackage

// File: rtl/txdefer_cnt.sv
module txdefer_cnt #(
    parameter int LEN_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic [LEN_W-1:0] len,
    output logic             expire
);
    localparam int EXT_W = LEN_W + 1;

    typedef struct packed {
        logic [LEN_W-1:0] cnt;
    } cnt_state_s;

    cnt_state_s       st_q, st_d;
    logic [EXT_W-1:0] cnt_inc;

    always_comb begin
        cnt_inc = {1'b0, st_q.cnt} + EXT_W'(1);
        expire  = run && (cnt_inc >= {1'b0, len});
        st_d    = st_q;
        if (clr) begin
            st_d.cnt = '0;
        end else if (run) begin
            st_d.cnt = expire ? '0 : cnt_inc[LEN_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/txdefer_ctrl.sv
module txdefer_ctrl
    import txdefer_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       nib_tick,
    input  logic       crs,
    input  logic       tx_req,
    input  logic       expire,
    output logic       cnt_clr,
    output logic       cnt_run,
    output gap_phase_e phase,
    output logic       start
);
    ctrl_state_s st_q, st_d;

    always_comb begin
        st_d       = st_q;
        st_d.start = 1'b0;
        cnt_clr    = 1'b0;
        cnt_run    = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                cnt_clr = 1'b1;
                if (tx_req) st_d.phase = crs ? PH_DEFER : PH_GAP1;
            end
            PH_DEFER: begin
                cnt_clr = 1'b1;
                if (!tx_req)  st_d.phase = PH_IDLE;
                else if (!crs) st_d.phase = PH_GAP1;
            end
            PH_GAP1: begin
                if (!tx_req) begin
                    st_d.phase = PH_IDLE;
                    cnt_clr    = 1'b1;
                end else if (crs) begin
                    st_d.phase = PH_DEFER;
                    cnt_clr    = 1'b1;
                end else if (nib_tick) begin
                    cnt_run = 1'b1;
                    if (expire) st_d.phase = PH_GAP2;
                end
            end
            PH_GAP2: begin
                if (!tx_req) begin
                    st_d.phase = PH_IDLE;
                    cnt_clr    = 1'b1;
                end else if (nib_tick) begin
                    cnt_run = 1'b1;
                    if (expire) begin
                        st_d.phase = PH_IDLE;
                        st_d.start = 1'b1;
                    end
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{phase: PH_IDLE, start: 1'b0};
        else        st_q <= st_d;
    end

    assign phase = st_q.phase;
    assign start = st_q.start;
endmodule

// File: rtl/txdefer_gap.sv
module txdefer_gap
    import txdefer_pkg::*;
#(
    parameter int GAP_W = LEN_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             nib_tick,
    input  logic             crs,
    input  logic             tx_req,
    input  logic [GAP_W-1:0] gap1_len,
    input  logic [GAP_W-1:0] gap2_len,
    output logic             tx_start,
    output logic [1:0]       phase
);
    gap_phase_e       cur_phase;
    logic             cnt_clr, cnt_run, expire;
    logic [GAP_W-1:0] cur_len;

    assign cur_len = (cur_phase == PH_GAP2) ? gap2_len : gap1_len;

    txdefer_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .nib_tick(nib_tick),
        .crs     (crs),
        .tx_req  (tx_req),
        .expire  (expire),
        .cnt_clr (cnt_clr),
        .cnt_run (cnt_run),
        .phase   (cur_phase),
        .start   (tx_start)
    );

    txdefer_cnt #(.LEN_W(GAP_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .run   (cnt_run),
        .len   (cur_len),
        .expire(expire)
    );

    assign phase = cur_phase;
endmodule

// File: rtl/txdefer_gap_chk.sv
module txdefer_gap_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       nib_tick,
    input logic       crs,
    input logic       tx_req,
    input logic       tx_start,
    input logic [1:0] phase
);
    a_r7_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |=> !tx_start);

    a_r7_strobe_idle: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> phase == 2'd0);

    a_r7_strobe_from_gap2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd3 && tx_req && nib_tick) |=> (tx_start || phase == 2'd3));

    a_r8_drop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_req |=> (phase == 2'd0 && !tx_start));

    a_r5_gap2_no_defer: assert property (@(posedge clk) disable iff (!rst_n)
        phase == 2'd3 |=> phase != 2'd1 && phase != 2'd2);

    a_r3_gap1_carrier: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd2 && crs && tx_req) |=> phase == 2'd1);

    a_r9_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd2 && !nib_tick && !crs && tx_req) |=> phase == 2'd2);
endmodule

bind txdefer_gap txdefer_gap_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .nib_tick(nib_tick),
    .crs     (crs),
    .tx_req  (tx_req),
    .tx_start(tx_start),
    .phase   (phase)
);

// File: tb/txdefer_gap_tb_top.sv
module txdefer_gap_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       nib_tick = 1'b0;
    logic       crs = 1'b0;
    logic       tx_req = 1'b0;
    logic [6:0] gap1_len = 7'd12;
    logic [6:0] gap2_len = 7'd6;
    logic       tx_start;
    logic [1:0] phase;

    int checks = 0;
    int fails = 0;
    int cycles = 0;

    // reference model state: phase, ticks still owed, strobe
    int m_ph = 0;
    int m_left = 0;
    bit m_start = 1'b0;

    always #10 clk = ~clk;

    txdefer_gap dut_i (
        .clk(clk), .rst_n(rst_n), .nib_tick(nib_tick), .crs(crs),
        .tx_req(tx_req), .gap1_len(gap1_len), .gap2_len(gap2_len),
        .tx_start(tx_start), .phase(phase)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic string tag_for(input int ph, input bit st);
        if (st) return "R7";
        case (ph)
            1: return "R2";
            2: return "R4";
            3: return "R5";
            default: return "R8";
        endcase
    endfunction

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (!rst_n) begin
            m_ph <= 0; m_start <= 1'b0; m_left <= 0;
        end else begin
            m_start <= 1'b0;
            if (!tx_req) begin
                m_ph <= 0;
            end else begin
                case (m_ph)
                    0: begin m_ph <= crs ? 1 : 2; m_left <= int'(gap1_len); end
                    1: if (!crs) begin m_ph <= 2; m_left <= int'(gap1_len); end
                    2: if (crs) m_ph <= 1;
                       else if (nib_tick) begin
                           if (m_left <= 1) begin m_ph <= 3; m_left <= int'(gap2_len); end
                           else m_left <= m_left - 1;
                       end
                    default: if (nib_tick) begin
                           if (m_left <= 1) begin m_ph <= 0; m_start <= 1'b1; end
                           else m_left <= m_left - 1;
                       end
                endcase
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            check(int'(phase) == m_ph, tag_for(m_ph, m_start), int'(phase), m_ph);
            check(tx_start == m_start, m_start ? "R7" : "R5", int'(tx_start), int'(m_start));
        end
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // Runs one request; counts ticks consumed in gap phases until strobe.
    task automatic run_req(input int period, input bit crs_gap2, input bit crs_gap1_pulse,
                           output int ticks, output bit got);
        int k = 0;
        bit pulsed = 1'b0;
        ticks = 0; got = 1'b0;
        @(negedge clk);
        tx_req = 1'b1;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (tx_start) begin got = 1'b1; break; end
            k++;
            nib_tick = (k % period) == 0;
            crs = 1'b0;
            if (crs_gap2 && phase == 2'd3) crs = 1'b1;
            if (crs_gap1_pulse && !pulsed && phase == 2'd2 && ticks >= 2) begin
                crs = 1'b1; nib_tick = 1'b0; pulsed = 1'b1; ticks = 0;
            end else if (nib_tick && (phase == 2'd2 || phase == 2'd3)) ticks++;
        end
        tx_req = 1'b0; nib_tick = 1'b0; crs = 1'b0;
    endtask

    initial begin
        int t;
        bit g;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        check(phase == 2'd0 && !tx_start, "R1", int'(phase), 0);
        rst_n = 1'b1;

        // plain gap 12 + 6
        run_req(3, 1'b0, 1'b0, t, g);
        check(g, "R7", int'(g), 1);
        check(t == 18, "R4", t, 18);

        // carrier held through second phase
        run_req(2, 1'b1, 1'b0, t, g);
        check(g, "R5", int'(g), 1);
        check(t == 18, "R5", t, 18);

        // carrier pulse in first phase restarts it
        run_req(2, 1'b0, 1'b1, t, g);
        check(g, "R3", int'(g), 1);
        check(t == 18, "R3", t, 18);

        // zero lengths
        gap1_len = 7'd0; gap2_len = 7'd0;
        run_req(1, 1'b0, 1'b0, t, g);
        check(g && t == 2, "R6", t, 2);
        gap1_len = 7'd0; gap2_len = 7'd5;
        run_req(4, 1'b0, 1'b0, t, g);
        check(g && t == 6, "R6", t, 6);

        // carrier at request time defers
        gap1_len = 7'd3; gap2_len = 7'd2;
        @(negedge clk); crs = 1'b1; tx_req = 1'b1;
        @(negedge clk);
        check(phase == 2'd1, "R2", int'(phase), 1);
        repeat (4) @(negedge clk);
        check(phase == 2'd1, "R2", int'(phase), 1);
        crs = 1'b0;
        @(negedge clk);
        check(phase == 2'd2, "R2", int'(phase), 2);
        // no tick: holds
        repeat (5) @(negedge clk);
        check(phase == 2'd2, "R9", int'(phase), 2);
        // reach phase 3 then drop request
        nib_tick = 1'b1;
        repeat (3) @(negedge clk);
        check(phase == 2'd3, "R4", int'(phase), 3);
        nib_tick = 1'b0; tx_req = 1'b0;
        @(negedge clk);
        check(phase == 2'd0 && !tx_start, "R8", int'(phase), 0);
        // new request after drop must take the full gap again
        run_req(1, 1'b0, 1'b0, t, g);
        check(g && t == 5, "R8", t, 5);

        // random traffic
        for (int r = 0; r < 4000; r++) begin
            @(negedge clk);
            if (tx_start || (tx_req && ($urandom % 200) == 0)) tx_req = 1'b0;
            else if (!tx_req && phase == 2'd0 && ($urandom % 4) == 0) begin
                if (($urandom % 3) == 0) gap1_len = 7'($urandom % 128);
                else gap1_len = 7'($urandom % 8);
                gap2_len = 7'($urandom % 8);
                tx_req = 1'b1;
            end
            nib_tick = ($urandom % 3) == 0;
            if (($urandom % 10) == 0) crs = ~crs;
        end
        tx_req = 1'b0; nib_tick = 1'b0; crs = 1'b0;
        repeat (3) @(negedge clk);
        check(phase == 2'd0, "R8", int'(phase), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule